// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the counter pair that follows an external dual-modulus prescaler in a frequency synthesizer feedback path. It runs on the prescaler's output clock and drives the prescaler's modulus-select line, so that each feedback period spans exactly N = P·B + A VCO cycles. P, the prescaler base modulus, is a parameter (8, 16 or 32). B is the number of prescaler output cycles per feedback period, and A is the number of those cycles in which the prescaler divides by P+1 instead of P.

A period runs in two parts. First the prescaler is held at P+1 for A cycles, and then it is held at P for the remaining B−A cycles. On the last prescaler cycle of the period the block raises a one-cycle feedback pulse for the phase detector. Settings presented on the A and B inputs are checked and latched only at the boundary between periods, which means a period in progress always completes with the values it started with. Settings that are not valid are reported and never latched. When the enable input is low the block is held idle and produces no output.

Top module: `swallow_div`

## Requirements
- R1: Each feedback period lasts P·B + A VCO cycles, counted as P+1 for each prescaler cycle with `modctl` high and P for each cycle with it low.
- R2: Within a period, `modctl` (1 = divide by P+1) is high on the first A prescaler cycles and low on the remaining B−A cycles. With A = 0 it stays low for the whole period, and with A = B it stays high for the whole period.
- R3: `fb_pulse` is high for exactly one prescaler cycle, on the last of the B cycles of each period, so that successive pulses are B cycles apart.
- R4: `a_in` is a 5-bit field, and only its low log2(P) bits set A: bits [3:0] when P = 16, bits [2:0] when P = 8, all five bits when P = 32. The upper bits have no effect on A or on `cfg_err`.
- R5: New values on `a_in` and `b_in` take effect only at the start of a period, meaning the cycle after `fb_pulse` or the first cycle after enabling. A change made mid-period does not alter the current period.
- R6: `cfg_err` is a combinational flag that is high whenever `b_in` < 3 or `b_in` < A.
- R7: A setting flagged by `cfg_err` is never latched. At a period boundary the previous A and B are reused. When starting from idle, the block stays idle with `modctl` and `fb_pulse` low until a valid setting is presented.
- R8: While `en` is low, `modctl` and `fb_pulse` are low from the next cycle onward. After `en` returns high, a fresh period starts from its first cycle using the setting present at that edge.
- R9: While `rst_n` is low, `modctl` and `fb_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Divider enable; low holds the counters idle |
| a_in | input | 5 | Swallow count A (low log2(P) bits used) |
| b_in | input | B_W (12) | Program count B, prescaler cycles per period |
| modctl | output | 1 | Prescaler modulus select, 1 = divide by P+1 |
| fb_pulse | output | 1 | One-cycle feedback pulse at terminal count |
| cfg_err | output | 1 | Presented A/B setting is illegal |

## Verification
The two functions that can fall in the same cycle are the terminal count of a period and the arrival of a new setting. The bench waits for `fb_pulse` and changes `a_in`/`b_in` in that same cycle, with both legal and illegal values, so that the reload edge coincides with the change. The same cycle is also used to drop or raise `en`. The behavioural queue model in the bench predicts from the requirements alone whether the next period uses the new or the old setting, and the observed `modctl` run length and pulse spacing are compared against it on every clock.

// File: rtl/swallow_div.sv
module swallow_div #(
  parameter int P       = 16,
  parameter int B_W     = 12,
  parameter int A_FIELD = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [A_FIELD-1:0] a_in,
  input  logic [B_W-1:0]     b_in,
  output logic               modctl,
  output logic               fb_pulse,
  output logic               cfg_err
);
  localparam int A_W = $clog2(P);

  logic [A_W-1:0] a_eff, a_cur;
  logic [B_W-1:0] b_cur, cnt;
  logic           run, last;

  assign a_eff    = a_in[A_W-1:0];
  assign cfg_err  = (b_in < B_W'(3)) || (b_in < B_W'(a_eff));
  assign last     = run && (cnt == b_cur - 1'b1);
  assign modctl   = run && (cnt < B_W'(a_cur));
  assign fb_pulse = last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      a_cur <= '0;
      b_cur <= '0;
    end else if (!en) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (!run || last) begin
      cnt <= '0;
      if (!cfg_err) begin
        a_cur <= a_eff;
        b_cur <= b_in;
        run   <= 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

module swallow_div_chk #(
  parameter int A_W = 4,
  parameter int B_W = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           modctl,
  input logic           fb_pulse,
  input logic           cfg_err,
  input logic           run,
  input logic [A_W-1:0] a_cur,
  input logic [B_W-1:0] b_cur
);
  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!modctl && !fb_pulse));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  assert_modctl_rise_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modctl) |-> ($past(fb_pulse) || !$past(run)));

  assert_hold_mid_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en && !fb_pulse) |=> ($stable(a_cur) && $stable(b_cur)));

  assert_no_illegal_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !run && cfg_err) |=> !run);

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> (!run || !$past(rst_n, 1) == 1'b0 || !modctl));
endmodule

bind swallow_div swallow_div_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .modctl(modctl), .fb_pulse(fb_pulse),
  .cfg_err(cfg_err), .run(run), .a_cur(a_cur), .b_cur(b_cur)
);

// File: tb/test_swallow_div.sv
module test_swallow_div;
  localparam int P   = 16;
  localparam int B_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [4:0] a_in = '0;
  logic [B_W-1:0] b_in = '0;
  logic modctl, fb_pulse, cfg_err;

  always #10 clk = ~clk;

  swallow_div #(.P(P), .B_W(B_W)) i_swallow_div (
    .clk(clk), .rst_n(rst_n), .en(en), .a_in(a_in), .b_in(b_in),
    .modctl(modctl), .fb_pulse(fb_pulse), .cfg_err(cfg_err)
  );

  int checks = 0;
  int failures = 0;
  string tag = "R9";

  bit q[$];
  bit active = 0;
  int ma = 0, mb = 0;
  int vco_acc = 0;
  int cycles = 0;

  function automatic bit legal(int a, int b);
    return (b >= 3) && (b >= a);
  endfunction

  function automatic void build(int a, int b);
    q.delete();
    for (int i = 0; i < b; i++) q.push_back(i < a);
  endfunction

  always @(posedge clk) begin
    automatic int a = int'(a_in) % P;
    automatic int b = int'(b_in);
    if (!rst_n || !en) begin
      q.delete();
      active = 0;
    end else if (!active) begin
      if (legal(a, b)) begin
        ma = a; mb = b; build(ma, mb); active = 1; vco_acc = 0;
      end
    end else begin
      void'(q.pop_front());
      if (q.size() == 0) begin
        if (legal(a, b)) begin ma = a; mb = b; end
        build(ma, mb);
        vco_acc = 0;
      end
    end
  end

  task automatic check(string what, string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    automatic int a = int'(a_in) % P;
    automatic int b = int'(b_in);
    automatic bit e_mod = active ? q[0] : 1'b0;
    automatic bit e_pls = active ? (q.size() == 1) : 1'b0;
    cycles++;
    check("modctl", (tag == "R9") ? "R9" : "R2", int'(modctl), int'(e_mod));
    check("fb_pulse", (tag == "R9") ? "R9" : "R3", int'(fb_pulse), int'(e_pls));
    check("cfg_err", "R6", int'(cfg_err), int'(!legal(a, b)));
    if (tag != "R9" && tag != "R3") check("modctl/fb_pulse", tag, int'(modctl) + 2 * int'(fb_pulse), int'(e_mod) + 2 * int'(e_pls));
    if (active) begin
      vco_acc += P + int'(modctl);
      if (e_pls) check("vco cycles per period", "R1", vco_acc, P * mb + ma);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic at_pulse();
    @(negedge clk iff fb_pulse);
    #2;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tag = "R9"; step(4);
    rst_n = 1'b1; step(1);

    tag = "R1"; a_in = 5; b_in = 8; en = 1'b1; step(30);
    tag = "R2"; at_pulse(); a_in = 0; b_in = 4; step(14);
    at_pulse(); a_in = 7; b_in = 7; step(16);
    at_pulse(); a_in = 15; b_in = 3000; step(3);
    tag = "R5"; a_in = 2; b_in = 5; step(3);
    at_pulse(); a_in = 3; b_in = 9; step(4);
    a_in = 1; b_in = 3; step(12);
    tag = "R4"; at_pulse(); a_in = 5'b10011; b_in = 5; step(14);
    a_in = 5'b11110; b_in = 14; step(20);
    tag = "R7"; at_pulse(); a_in = 0; b_in = 2; step(20);
    a_in = 9; b_in = 4; step(12);
    tag = "R8"; step(3); en = 1'b0; a_in = 4; b_in = 6; step(5);
    en = 1'b1; step(20);
    at_pulse(); en = 1'b0; step(3);
    tag = "R7"; a_in = 0; b_in = 1; en = 1'b1; step(6);
    b_in = 5; a_in = 5; step(12);
    tag = "R9"; rst_n = 1'b0; step(3);
    rst_n = 1'b1; tag = "R1"; a_in = 13; b_in = 20; step(45);
    finish_run();
  end
endmodule